// File: doc/BRIEF.md
# Adaptive Default Fetch-Size Predictor

This block chooses how many neighbouring cache lines to bring in on a miss when no footprint history is available for the sector. It behaves like a cache whose line size adapts at run time among groups of 4, 8 and 16 lines of 8 bytes, that is 32, 64 or 128 bytes, inside a 16-line sector. Each of the three candidate group sizes has a cost meter. Every footprint that leaves the active-sector tracking is scored against all three candidates. The score counts the used lines that a candidate group would not have brought in and the lines it would have brought in for nothing.

A retirement carries a 16-bit footprint (bit b set means line b of the sector was used) and the 4-bit index of the line that opened the sector. A three-phase sequencer scores the retirement and then commits it to the meters. A fetch request carries the index of the missing line. One cycle later the block returns an aligned mask of lines to fetch, sized by the cheapest meter. The same request port serves a first miss in a sector and a repeat miss during recovery in a sector that this predictor opened. Both use the same selection.

Top module: `fetch_size_predictor`

## Requirements
- R1: After reset all three meters read zero, `retire_ready` is high and `fetch_valid` is low. A request that arrives before any retirement therefore gets a 4-line group.
- R2: A retirement is taken only on a rising edge where `retire_valid` and `retire_ready` are both high. `retire_ready` is then low for exactly the next two cycles. A `retire_valid` presented during those two cycles has no effect on the meters.
- R3: For candidate k (k = 0, 1, 2, group of 4<<k lines), the group is the aligned block containing the nominating line. Its cost is twice the number of footprint bits outside the group plus the number of group bits clear in the footprint. Each meter adds its own cost.
- R4: The meters change only at the second edge after the retirement is taken. A request sampled at any edge where `retire_ready` has returned high sees the updated meters.
- R5: The selected candidate is the one whose meter is lowest. On equal meters the smaller group wins.
- R6: One cycle after an edge with `req_valid` high, `fetch_valid` is high. `fetch_mask` bit b is set exactly when b and `req_line` lie in the same aligned group of the selected size.
- R7: One cycle after an edge with `req_valid` low, `fetch_valid` is low.
- R8: Meters are 16-bit. If any meter plus its cost would exceed 65535, all three meters take (meter + cost) shifted right by one. Otherwise each takes meter + cost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_valid | input | 1 | A recorded footprint is being retired |
| retire_fp | input | 16 | Retired footprint, bit b = line b used |
| retire_nom | input | 4 | Line index that opened the sector |
| retire_ready | output | 1 | Sequencer idle, a retirement can be taken |
| req_valid | input | 1 | Fetch-size request for a missing line |
| req_line | input | 4 | Index of the missing line in its sector |
| fetch_valid | output | 1 | `fetch_mask` answers last cycle's request |
| fetch_mask | output | 16 | Aligned group of lines to fetch |

Sequencer states: ST_IDLE (waits; moves to ST_SCORE when a retirement is taken), ST_SCORE (registers the three costs; always moves to ST_COMMIT), ST_COMMIT (adds or halves the meters; always returns to ST_IDLE).

## Verification
A wrong cost or a wrong meter value stays hidden until it changes which meter is lowest. When that happens, the next request shows a mask of the wrong width. The bench keeps an arithmetic model of the meters and issues a request after every retirement, so a divergence is reported in the first request after it changes the ranking. Long runs of full footprints drive the meters through saturation, so an off-by-one in the halving rule shifts later tie outcomes and also becomes visible. A sequencer that takes a retirement while busy corrupts the model match on the following request.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
    localparam int SECTOR_LINES  = 16;
    localparam int LINE_W        = $clog2(SECTOR_LINES);
    localparam int MIN_GROUP_LG  = 2;
    localparam int NUM_CAND      = LINE_W - MIN_GROUP_LG + 1;
    localparam int COST_W        = $clog2(2 * SECTOR_LINES + 1);
    localparam int SEL_W         = $clog2(NUM_CAND);

    typedef logic [SECTOR_LINES-1:0] fp_t;
    typedef logic [LINE_W-1:0]       line_t;
    typedef logic [COST_W-1:0]       cost_t;
    typedef logic [SEL_W-1:0]        sel_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCORE,
        ST_COMMIT
    } seq_state_t;

    function automatic fp_t group_mask(input int lg, input line_t line);
        fp_t m;
        for (int b = 0; b < SECTOR_LINES; b++)
            m[b] = ((b >> lg) == (int'(line) >> lg));
        return m;
    endfunction

    function automatic logic [LINE_W:0] bit_count(input fp_t v);
        logic [LINE_W:0] n;
        n = '0;
        for (int b = 0; b < SECTOR_LINES; b++)
            n = n + {{LINE_W{1'b0}}, v[b]};
        return n;
    endfunction
endpackage

// File: rtl/fsp_cost_calc.sv
module fsp_cost_calc
    import fsp_pkg::*;
(
    input  fp_t                              fp,
    input  line_t                            nom,
    output logic [NUM_CAND-1:0][COST_W-1:0]  cost
);
    for (genvar g = 0; g < NUM_CAND; g++) begin : g_cand
        fp_t             blk;
        logic [LINE_W:0] missed;
        logic [LINE_W:0] extra;
        always_comb begin
            blk     = group_mask(MIN_GROUP_LG + g, nom);
            missed  = bit_count(fp & ~blk);
            extra   = bit_count(~fp & blk);
            cost[g] = COST_W'(2 * int'(missed) + int'(extra));
        end
    end
endmodule

// File: rtl/fsp_meter_bank.sv
module fsp_meter_bank
    import fsp_pkg::*;
#(
    parameter int METER_W = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              commit,
    input  logic [NUM_CAND-1:0][COST_W-1:0]   cost,
    output logic [NUM_CAND-1:0][METER_W-1:0]  meters
);
    logic [NUM_CAND-1:0][METER_W:0]   sum;
    logic [NUM_CAND-1:0][METER_W-1:0] nxt;
    logic                             any_wrap;

    always_comb begin
        any_wrap = 1'b0;
        for (int g = 0; g < NUM_CAND; g++) begin
            sum[g]   = {1'b0, meters[g]} + (METER_W+1)'(cost[g]);
            any_wrap = any_wrap | sum[g][METER_W];
        end
        for (int g = 0; g < NUM_CAND; g++)
            nxt[g] = any_wrap ? sum[g][METER_W:1] : sum[g][METER_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            meters <= '0;
        else if (commit)
            meters <= nxt;
    end

    AST_METER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(meters)); // R4

    for (genvar g = 0; g < NUM_CAND; g++) begin : g_chk
        AST_METER_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
            commit && !any_wrap |=> meters[g] >= $past(meters[g])); // R3
        AST_METER_HALVED: assert property (@(posedge clk) disable iff (!rst_n)
            commit && any_wrap |=> {1'b0, meters[g]} <=
                ({1'b0, $past(meters[g])} >> 1) + (METER_W+1)'(SECTOR_LINES)); // R8
    end
endmodule

// File: rtl/fsp_select.sv
module fsp_select
    import fsp_pkg::*;
#(
    parameter int METER_W = 16
) (
    input  logic [NUM_CAND-1:0][METER_W-1:0] meters,
    input  line_t                            line,
    output sel_t                             sel,
    output fp_t                              mask
);
    always_comb begin
        sel = '0;
        for (int g = 1; g < NUM_CAND; g++)
            if (meters[g] < meters[sel])
                sel = SEL_W'(g);
        mask = group_mask(MIN_GROUP_LG + int'(sel), line);
    end
endmodule

// File: rtl/fetch_size_predictor.sv
module fetch_size_predictor
    import fsp_pkg::*;
#(
    parameter int METER_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     retire_valid,
    input  logic [SECTOR_LINES-1:0]  retire_fp,
    input  logic [LINE_W-1:0]        retire_nom,
    output logic                     retire_ready,
    input  logic                     req_valid,
    input  logic [LINE_W-1:0]        req_line,
    output logic                     fetch_valid,
    output logic [SECTOR_LINES-1:0]  fetch_mask
);
    seq_state_t state, state_nxt;
    fp_t        fp_q;
    line_t      nom_q;
    logic [NUM_CAND-1:0][COST_W-1:0]  cost_c, cost_q;
    logic [NUM_CAND-1:0][METER_W-1:0] meters;
    sel_t       sel;
    fp_t        mask_c;
    logic       take;

    assign retire_ready = (state == ST_IDLE);
    assign take         = retire_valid && retire_ready;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (take) state_nxt = ST_SCORE;
            ST_SCORE:  state_nxt = ST_COMMIT;
            ST_COMMIT: state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fp_q        <= '0;
            nom_q       <= '0;
            cost_q      <= '0;
            fetch_valid <= 1'b0;
            fetch_mask  <= '0;
        end else begin
            if (take) begin
                fp_q  <= retire_fp;
                nom_q <= retire_nom;
            end
            if (state == ST_SCORE)
                cost_q <= cost_c;
            fetch_valid <= req_valid;
            if (req_valid)
                fetch_mask <= mask_c;
        end
    end

    fsp_cost_calc u_cost (
        .fp   (fp_q),
        .nom  (nom_q),
        .cost (cost_c)
    );

    fsp_meter_bank #(.METER_W(METER_W)) u_meters (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (state == ST_COMMIT),
        .cost   (cost_q),
        .meters (meters)
    );

    fsp_select #(.METER_W(METER_W)) u_sel (
        .meters (meters),
        .line   (req_line),
        .sel    (sel),
        .mask   (mask_c)
    );

    AST_BUSY_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid && retire_ready |=> !retire_ready ##1 !retire_ready); // R2
    AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> fetch_valid && fetch_mask[$past(req_line)]); // R6
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !fetch_valid); // R7
    AST_MASK_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> ($countones(fetch_mask) == 4 || $countones(fetch_mask) == 8
                         || $countones(fetch_mask) == 16)); // R5
endmodule

// File: tb/fetch_size_predictor_test.sv
module fetch_size_predictor_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        retire_valid = 1'b0;
    logic [15:0] retire_fp = '0;
    logic [3:0]  retire_nom = '0;
    logic        retire_ready;
    logic        req_valid = 1'b0;
    logic [3:0]  req_line = '0;
    logic        fetch_valid;
    logic [15:0] fetch_mask;

    int          errors = 0;
    int          checks = 0;
    int          cycles = 0;
    bit          done = 0;
    int          mdl[3];
    int          halvings = 0;
    int unsigned seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    fetch_size_predictor uut (
        .clk(clk), .rst_n(rst_n),
        .retire_valid(retire_valid), .retire_fp(retire_fp), .retire_nom(retire_nom),
        .retire_ready(retire_ready),
        .req_valid(req_valid), .req_line(req_line),
        .fetch_valid(fetch_valid), .fetch_mask(fetch_mask)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: act=%0d exp<=200000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic int unsigned rnd();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    function automatic logic [15:0] grp(input int size, input int line);
        int lo = (line / size) * size;
        return 16'(((32'd1 << size) - 1) << lo);
    endfunction

    function automatic int pick();
        int best = 0;
        for (int k = 1; k < 3; k++)
            if (mdl[k] < mdl[best]) best = k;
        return best;
    endfunction

    function automatic void model_retire(input logic [15:0] fp, input int nom);
        int s[3];
        bit wrap = 0;
        for (int k = 0; k < 3; k++) begin
            logic [15:0] blk = grp(4 << k, nom);
            int missed = 0, extra = 0;
            for (int b = 0; b < 16; b++) begin
                if (fp[b] && !blk[b]) missed++;
                if (!fp[b] && blk[b]) extra++;
            end
            s[k] = mdl[k] + 2 * missed + extra;
            if (s[k] > 65535) wrap = 1;
        end
        if (wrap) halvings++;
        for (int k = 0; k < 3; k++) mdl[k] = wrap ? (s[k] >> 1) : s[k];
    endfunction

    task automatic do_retire(input logic [15:0] fp, input int nom, input bit junk);
        @(negedge clk);
        check(retire_ready == 1'b1, "R2 ready before take", retire_ready, 1);
        retire_valid = 1'b1;
        retire_fp    = fp;
        retire_nom   = 4'(nom);
        @(negedge clk);
        check(retire_ready == 1'b0, "R2 busy cycle 1", retire_ready, 0);
        if (junk) begin
            retire_fp  = ~fp;
            retire_nom = 4'(nom + 5);
        end else begin
            retire_valid = 1'b0;
        end
        @(negedge clk);
        check(retire_ready == 1'b0, "R2 busy cycle 2", retire_ready, 0);
        @(negedge clk);
        retire_valid = 1'b0;
        check(retire_ready == 1'b1, "R2 ready returns", retire_ready, 1);
        model_retire(fp, nom);
    endtask

    task automatic do_req(input int line, input string req, input bit check_idle);
        logic [15:0] exp = grp(4 << pick(), line);
        @(negedge clk);
        req_valid = 1'b1;
        req_line  = 4'(line);
        @(negedge clk);
        req_valid = 1'b0;
        check(fetch_valid == 1'b1, {req, " R6 valid"}, fetch_valid, 1);
        check(fetch_mask == exp, {req, " R3 R5 R6 mask"}, fetch_mask, exp);
        if (check_idle) begin
            @(negedge clk);
            check(fetch_valid == 1'b0, "R7 idle", fetch_valid, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(retire_ready == 1'b1, "R1 ready after reset", retire_ready, 1);
        check(fetch_valid == 1'b0, "R1 no fetch after reset", fetch_valid, 0);
        for (int l = 0; l < 16; l++) do_req(l, "R1 reset sweep", l == 15);

        do_retire(16'hFFFF, 3, 1'b1);
        for (int l = 0; l < 16; l++) do_req(l, "R4 full footprint sweep", 1'b0);

        do_retire(16'h0F00, 9, 1'b0);
        do_retire(16'h0F00, 10, 1'b0);
        for (int l = 0; l < 16; l++) do_req(l, "R5 after local retires", 1'b0);

        for (int i = 0; i < 9000; i++) begin
            int unsigned r = rnd();
            int nom = int'(r[3:0]);
            logic [15:0] fp;
            case (r[5:4])
                2'd0:    fp = 16'((r[11:8] | (4'd1 << nom[1:0]))) << (nom & 12);
                2'd1:    fp = 16'hFFFF;
                default: fp = 16'(rnd()) | (16'd1 << nom);
            endcase
            do_retire(fp, nom, r[7:6] == 2'd0);
            do_req(int'(r[15:12]), "R4 R8 random", r[19:16] == 4'd0);
        end
        if (halvings == 0) $display("note: no meter halving occurred");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule